// File: doc/BRIEF.md
# PWM Fault Shutdown Controller

This block sits between a multi-channel PWM generator and the output pins. It forces every PWM output to its inactive level when an enabled fault is asserted on one of two fault inputs. The fault inputs are active low, so several open-drain sources can share one input. Each fault input has its own enable bit, its own restart mode and its own sticky status bit. The generator delivers its raw demand as one high-side bit and one low-side bit per output pair. The block applies the configured output polarity to that demand and drives an output-enable vector that comes from a pin-enable field.

Each fault input has one of two restart policies. Latched mode holds the outputs off until the fault has gone away and software has acknowledged it. Cycle-by-cycle mode releases the outputs by itself once the fault has gone away. In both modes the outputs come back only on a period-start strobe from the PWM timebase, so a pulse is never cut short at its start. Each fault input passes through a two-flop synchroniser. A fault blanks the outputs combinationally from the synchronised level, and the release is registered.

Top module: `pwm_fault_guard`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is high, both status bits and `shutdown` read 0 and the fault configuration reads 0. The pin-enable field loads 3'b101 when `rst_oe_cfg` is 1 on a block with 8 outputs (3'b100 on a block with 6 outputs), and loads 3'b000 when `rst_oe_cfg` is 0.
- R2: The pin-enable field is written through `oe_wr`/`oe_wdata`. A value v of 0 enables no outputs. A value v of 1 or more enables the outputs with index below 2*(v-1), capped at the number of outputs. The new mask appears on `pin_oe` after the write edge.
- R3: Output 2k is the high side of pair k and output 2k+1 is the low side. A pin drives its polarity input (`pol_hi` or `pol_lo`) when its demand bit is 1 and `shutdown` is 0. Otherwise it drives the inverse of that polarity input.
- R4: An enabled fault input held low asserts `shutdown` after the second rising edge, through the two-flop synchroniser. All pins go inactive in that same cycle. The status bit of that fault is set one edge later.
- R5: A fault input whose enable bit is 0 has no effect: `shutdown` stays 0, the pins follow the demand, and its status bit stays 0.
- R6: In latched mode (mode bit 0), once the input is high again the outputs stay inactive until two things have happened. First, the status bit has been cleared by a write-1-to-clear on `clr_wr`/`clr_mask`. Second, a later `period_start` edge has occurred, and on that edge the outputs resume.
- R7: A status clear is ignored while the synchronised fault input is still low.
- R8: In cycle-by-cycle mode (mode bit 1), the outputs resume on the first `period_start` edge at which the synchronised input is high, and the status bit clears on that same edge. A `period_start` while the input is low changes nothing.
- R9: When both faults are enabled and active, the outputs stay inactive until each fault has met its own release condition.
- R10: Field positions: `cfg_wdata` bit 0 enables fault A, bit 1 is the mode of A, bit 2 enables fault B and bit 3 is the mode of B. In `flt_status` and `clr_mask`, bit 0 is fault A and bit 1 is fault B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_oe_cfg | input | 1 | Selects the pin-enable value loaded at reset |
| pwm_hi | input | NUM_OUT/2 | High-side demand, one bit per pair |
| pwm_lo | input | NUM_OUT/2 | Low-side demand, one bit per pair |
| pol_hi | input | 1 | Active level of the high-side pins |
| pol_lo | input | 1 | Active level of the low-side pins |
| period_start | input | 1 | One-cycle strobe at the start of each PWM period |
| flt_a_n | input | 1 | Fault A, active low, asynchronous |
| flt_b_n | input | 1 | Fault B, active low, asynchronous |
| cfg_wr | input | 1 | Write strobe for the fault configuration |
| cfg_wdata | input | 4 | Fault enables and modes |
| clr_wr | input | 1 | Strobe for the status write-1-to-clear |
| clr_mask | input | 2 | Status bits to clear |
| oe_wr | input | 1 | Write strobe for the pin-enable field |
| oe_wdata | input | 3 | New value of the pin-enable field |
| pin_out | output | NUM_OUT | Output pin levels |
| pin_oe | output | NUM_OUT | Output pin enables |
| flt_status | output | 2 | Sticky fault status bits |
| shutdown | output | 1 | All PWM outputs forced inactive |

## Verification
A wrong hold or status flip-flop shows up at the ports on the next period-start edge. In that case the pins resume a period early or stay dark a period too long, and `flt_status` differs from the expected value within one cycle of the offending event. A synchroniser of the wrong depth moves the shutdown edge by whole cycles. A reference model steps with every clock, and the comparison catches that shift in the very cycle it happens. Polarity or pair-ordering faults are visible on `pin_out` in every cycle, both while the block is in shutdown and while it is out of shutdown.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;

    localparam int N_FLT = 2;

    // per-fault configuration, en in bit 0 and cycle-by-cycle mode in bit 1
    typedef struct packed {
        logic cbc;
        logic en;
    } flt_cfg_t;

    // pin-enable value loaded at reset when the pins start out driven
    function automatic logic [2:0] rst_pin_code(input int n_out);
        return (n_out >= 8) ? 3'b101 : 3'b100;
    endfunction

    // number of pins that a pin-enable value switches on
    function automatic int oe_count(input logic [2:0] v);
        return (v == 3'd0) ? 0 : 2 * (int'(v) - 1);
    endfunction

endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fault_n,
    output logic lvl
);
    logic [STAGES-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= {q[STAGES-2:0], ~fault_n};
    end

    assign lvl = q[STAGES-1];
endmodule

// File: rtl/fault_chan.sv
module fault_chan
    import pwm_fault_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lvl,
    input  flt_cfg_t cfg,
    input  logic     period_start,
    input  logic     clr,
    output logic     status,
    output logic     shut
);
    logic hold_q, status_q;
    logic set_c, rel_c;

    assign set_c = cfg.en & lvl;
    assign rel_c = cfg.en & hold_q & ~lvl & period_start & (cfg.cbc | ~status_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= 1'b0;
            status_q <= 1'b0;
        end else begin
            if (!cfg.en)    hold_q <= 1'b0;
            else if (set_c) hold_q <= 1'b1;
            else if (rel_c) hold_q <= 1'b0;

            if (set_c)                status_q <= 1'b1;
            else if (rel_c & cfg.cbc) status_q <= 1'b0;
            else if (clr & ~lvl)      status_q <= 1'b0;
        end
    end

    assign status = status_q;
    assign shut   = cfg.en & (lvl | hold_q);

    // R4: an enabled, synchronised fault sets status on the next edge
    p_status_set_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && lvl) |=> status_q);

    // R7: a clear while the fault is still low leaves status set
    p_clr_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (status_q && lvl && clr) |=> status_q);

    // R6: a latched fault with status still set cannot release
    p_latched_waits_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && !cfg.cbc && hold_q && status_q) |=> (hold_q || !cfg.en));

    // R8: a hold that drops while enabled always drops on a period start
    p_release_on_period_r8: assert property (@(posedge clk) disable iff (rst)
        (!hold_q && $past(hold_q) && $past(cfg.en) && cfg.en) |-> $past(period_start));
endmodule

// File: rtl/pin_drive.sv
module pin_drive
    import pwm_fault_pkg::*;
#(
    parameter int N_PAIRS = 4
) (
    input  logic [N_PAIRS-1:0]   hi_dem,
    input  logic [N_PAIRS-1:0]   lo_dem,
    input  logic                 pol_hi,
    input  logic                 pol_lo,
    input  logic                 shutdown,
    input  logic [2:0]           pin_en,
    output logic [2*N_PAIRS-1:0] pin_out,
    output logic [2*N_PAIRS-1:0] pin_oe
);
    for (genvar k = 0; k < N_PAIRS; k++) begin : g_pair
        assign pin_out[2*k]   = ~((hi_dem[k] & ~shutdown) ^ pol_hi);
        assign pin_out[2*k+1] = ~((lo_dem[k] & ~shutdown) ^ pol_lo);
        assign pin_oe[2*k]    = oe_count(pin_en) > 2*k;
        assign pin_oe[2*k+1]  = oe_count(pin_en) > 2*k + 1;
    end
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
    import pwm_fault_pkg::*;
#(
    parameter int NUM_OUT     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rst_oe_cfg,
    input  logic [NUM_OUT/2-1:0] pwm_hi,
    input  logic [NUM_OUT/2-1:0] pwm_lo,
    input  logic                 pol_hi,
    input  logic                 pol_lo,
    input  logic                 period_start,
    input  logic                 flt_a_n,
    input  logic                 flt_b_n,
    input  logic                 cfg_wr,
    input  logic [3:0]           cfg_wdata,
    input  logic                 clr_wr,
    input  logic [1:0]           clr_mask,
    input  logic                 oe_wr,
    input  logic [2:0]           oe_wdata,
    output logic [NUM_OUT-1:0]   pin_out,
    output logic [NUM_OUT-1:0]   pin_oe,
    output logic [1:0]           flt_status,
    output logic                 shutdown
);
    localparam int         NUM_PAIRS = NUM_OUT / 2;
    localparam logic [2:0] PIN_CODE  = rst_pin_code(NUM_OUT);

    logic [2*N_FLT-1:0] cfg_q;
    logic [2:0]         pin_en_q;
    logic [N_FLT-1:0]   flt_n, lvl, shut_v;
    flt_cfg_t           cfg_v [N_FLT];

    assign flt_n = {flt_b_n, flt_a_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            pin_en_q <= rst_oe_cfg ? PIN_CODE : 3'b000;
        end else begin
            if (cfg_wr) cfg_q    <= cfg_wdata;
            if (oe_wr)  pin_en_q <= oe_wdata;
        end
    end

    for (genvar ch = 0; ch < N_FLT; ch++) begin : g_flt
        assign cfg_v[ch] = flt_cfg_t'(cfg_q[2*ch +: 2]);

        fault_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst     (rst),
            .fault_n (flt_n[ch]),
            .lvl     (lvl[ch])
        );

        fault_chan u_chan (
            .clk          (clk),
            .rst          (rst),
            .lvl          (lvl[ch]),
            .cfg          (cfg_v[ch]),
            .period_start (period_start),
            .clr          (clr_wr & clr_mask[ch]),
            .status       (flt_status[ch]),
            .shut         (shut_v[ch])
        );
    end

    assign shutdown = |shut_v;

    pin_drive #(.N_PAIRS(NUM_PAIRS)) u_pins (
        .hi_dem   (pwm_hi),
        .lo_dem   (pwm_lo),
        .pol_hi   (pol_hi),
        .pol_lo   (pol_lo),
        .shutdown (shutdown),
        .pin_en   (pin_en_q),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    // R3: in shutdown every pin sits at its inactive level
    p_shut_inactive_r3: assert property (@(posedge clk) disable iff (rst)
        shutdown |-> (pin_out == {NUM_PAIRS{~pol_lo, ~pol_hi}}));

    // R5: with both faults disabled there is never a shutdown
    p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[0] == 1'b0 && cfg_q[2] == 1'b0) |-> !shutdown);

    // R2: a zero pin-enable field drives no pin
    p_oe_none_r2: assert property (@(posedge clk) disable iff (rst)
        (pin_en_q == 3'b000) |-> (pin_oe == '0));
endmodule

// File: tb/tb_pwm_fault_guard.sv
module tb_pwm_fault_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NO = 8;
    localparam int NP = NO / 2;

    logic clk = 0;
    logic rst, rst_oe_cfg, pol_hi, pol_lo, period_start;
    logic flt_a_n, flt_b_n, cfg_wr, clr_wr, oe_wr;
    logic [NP-1:0] pwm_hi, pwm_lo;
    logic [3:0] cfg_wdata;
    logic [1:0] clr_mask;
    logic [2:0] oe_wdata;
    logic [NO-1:0] pin_out, pin_oe;
    logic [1:0] flt_status;
    logic shutdown;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_fault_guard #(.NUM_OUT(NO)) dut (
        .clk(clk), .rst(rst), .rst_oe_cfg(rst_oe_cfg),
        .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .pol_hi(pol_hi), .pol_lo(pol_lo),
        .period_start(period_start), .flt_a_n(flt_a_n), .flt_b_n(flt_b_n),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .clr_wr(clr_wr), .clr_mask(clr_mask),
        .oe_wr(oe_wr), .oe_wdata(oe_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
        .flt_status(flt_status), .shutdown(shutdown)
    );

    // expected pin levels from demand, polarity and a shutdown flag
    function automatic logic [NO-1:0] exp_pins(input bit shut);
        logic [NO-1:0] r;
        for (int k = 0; k < NP; k++) begin
            r[2*k]   = (pwm_hi[k] && !shut) ? pol_hi : !pol_hi;
            r[2*k+1] = (pwm_lo[k] && !shut) ? pol_lo : !pol_lo;
        end
        return r;
    endfunction

    function automatic logic [NO-1:0] exp_oe(input bit [2:0] v);
        int n;
        logic [NO-1:0] r;
        n = (v == 0) ? 0 : 2 * (v - 1);
        for (int i = 0; i < NO; i++) r[i] = (i < n);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit [1:0] m_s1, m_s2, m_st, m_hold;
    bit [3:0] m_cfg;
    bit [2:0] m_pe;

    always @(posedge clk) begin
        bit [1:0] n_st, n_hold;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_st = 0; m_hold = 0; m_cfg = 0;
            m_pe = rst_oe_cfg ? 3'b101 : 3'b000;
        end else begin
            for (int ch = 0; ch < 2; ch++) begin
                bit en, cbc, lv, rel;
                en  = m_cfg[2*ch];
                cbc = m_cfg[2*ch+1];
                lv  = m_s2[ch];
                rel = en && m_hold[ch] && !lv && period_start && (cbc || !m_st[ch]);
                n_hold[ch] = !en ? 1'b0 : (en && lv) ? 1'b1 : rel ? 1'b0 : m_hold[ch];
                if (en && lv)                               n_st[ch] = 1;
                else if (rel && cbc)                        n_st[ch] = 0;
                else if (clr_wr && clr_mask[ch] && !lv)     n_st[ch] = 0;
                else                                        n_st[ch] = m_st[ch];
            end
            m_hold = n_hold;
            m_st   = n_st;
            m_s2   = m_s1;
            m_s1   = {~flt_b_n, ~flt_a_n};
            if (cfg_wr) m_cfg = cfg_wdata;
            if (oe_wr)  m_pe  = oe_wdata;
        end
    end

    // per-cycle comparison against the model
    always @(posedge clk) begin
        bit m_shut;
        #2;
        m_shut = 0;
        for (int ch = 0; ch < 2; ch++)
            if (m_cfg[2*ch] && (m_s2[ch] || m_hold[ch])) m_shut = 1;
        chk("R3 model pins", 32'(pin_out), 32'(exp_pins(m_shut)));
        chk("R2 model oe", 32'(pin_oe), 32'(exp_oe(m_pe)));
        chk("R6 model status", 32'(flt_status), 32'(m_st));
        chk("R4 model shutdown", 32'(shutdown), 32'(m_shut));
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [3:0] v);
        cfg_wr = 1; cfg_wdata = v; @(negedge clk); cfg_wr = 0;
    endtask

    task automatic wr_oe(input logic [2:0] v);
        oe_wr = 1; oe_wdata = v; @(negedge clk); oe_wr = 0;
    endtask

    task automatic clr(input logic [1:0] m);
        clr_wr = 1; clr_mask = m; @(negedge clk); clr_wr = 0;
    endtask

    task automatic pulse_ps();
        period_start = 1; @(negedge clk); period_start = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        total++; fails++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst = 1; rst_oe_cfg = 1; pol_hi = 1; pol_lo = 0; period_start = 0;
        flt_a_n = 1; flt_b_n = 1; cfg_wr = 0; cfg_wdata = 0; clr_wr = 0;
        clr_mask = 0; oe_wr = 0; oe_wdata = 0;
        pwm_hi = 4'b1010; pwm_lo = 4'b0101;
        step(3);
        chk("R1 reset oe code", 32'(pin_oe), 32'hFF);
        chk("R1 reset status", 32'(flt_status), 0);
        chk("R1 reset shutdown", 32'(shutdown), 0);
        rst = 0;
        step(1);
        chk("R3 pins normal", 32'(pin_out), 32'(exp_pins(0)));
        pol_hi = 0; pol_lo = 1; pwm_hi = 4'b0110;
        step(1);
        chk("R3 pins swapped polarity", 32'(pin_out), 32'(exp_pins(0)));
        pol_hi = 1; pol_lo = 0; pwm_hi = 4'b1010;

        wr_oe(3'd3); chk("R2 oe v3", 32'(pin_oe), 32'h0F);
        wr_oe(3'd0); chk("R2 oe v0", 32'(pin_oe), 32'h00);
        wr_oe(3'd4); chk("R2 oe v4", 32'(pin_oe), 32'h3F);
        wr_oe(3'd5); chk("R2 oe v5", 32'(pin_oe), 32'hFF);

        // R5: disabled faults
        flt_a_n = 0; flt_b_n = 0;
        step(4);
        chk("R5 no shutdown", 32'(shutdown), 0);
        chk("R5 pins follow demand", 32'(pin_out), 32'(exp_pins(0)));
        chk("R5 status quiet", 32'(flt_status), 0);
        flt_a_n = 1; flt_b_n = 1;
        step(3);

        // R4, R6, R7, R10: latched fault A
        wr_cfg(4'b0001);
        flt_a_n = 0;
        step(1);
        chk("R4 not yet after one edge", 32'(shutdown), 0);
        step(1);
        chk("R4 shutdown after two edges", 32'(shutdown), 1);
        chk("R4 pins inactive", 32'(pin_out), 32'(exp_pins(1)));
        chk("R4 status not yet", 32'(flt_status), 0);
        step(1);
        chk("R10 status A in bit0", 32'(flt_status), 32'h1);
        clr(2'b01);
        chk("R7 clear ignored while low", 32'(flt_status), 32'h1);
        flt_a_n = 1;
        step(3);
        pulse_ps();
        chk("R6 no release before clear", 32'(shutdown), 1);
        clr(2'b01);
        chk("R6 status cleared", 32'(flt_status), 0);
        chk("R6 still off until period", 32'(shutdown), 1);
        pulse_ps();
        chk("R6 resume on period", 32'(shutdown), 0);
        chk("R6 pins normal", 32'(pin_out), 32'(exp_pins(0)));

        // R8: cycle-by-cycle fault B
        wr_cfg(4'b1100);
        flt_b_n = 0;
        step(3);
        chk("R8 shutdown", 32'(shutdown), 1);
        chk("R10 status B in bit1", 32'(flt_status), 32'h2);
        pulse_ps();
        chk("R8 period while low", 32'(shutdown), 1);
        flt_b_n = 1;
        step(2);
        chk("R8 waits for period", 32'(shutdown), 1);
        chk("R8 status held", 32'(flt_status), 32'h2);
        pulse_ps();
        chk("R8 resumed", 32'(shutdown), 0);
        chk("R8 status auto clear", 32'(flt_status), 0);

        // R9: both faults, A latched, B cycle-by-cycle
        wr_cfg(4'b1101);
        flt_a_n = 0; flt_b_n = 0;
        step(3);
        chk("R9 both status", 32'(flt_status), 32'h3);
        flt_b_n = 1;
        step(3);
        pulse_ps();
        chk("R9 A still holds", 32'(shutdown), 1);
        chk("R9 B cleared alone", 32'(flt_status), 32'h1);
        flt_a_n = 1;
        step(3);
        clr(2'b01);
        pulse_ps();
        chk("R9 all released", 32'(shutdown), 0);
        chk("R9 pins normal", 32'(pin_out), 32'(exp_pins(0)));

        // R1: reset with pins handed to general I/O
        rst = 1; rst_oe_cfg = 0;
        step(2);
        chk("R1 reset oe zero", 32'(pin_oe), 0);
        chk("R1 reset status zero", 32'(flt_status), 0);
        rst = 0;
        step(2);
        finish_run();
    end
endmodule